// File: doc/BRIEF.md
# Clock Rate Change Controller

This block decides when a new system clock rate takes effect. The clock can run at the oscillator rate, at twice the oscillator rate, or at half the oscillator rate. Software writes a rate code, a mode bit and a 4-bit wake-up wait field in a single write strobe. The block reports the effective code on `rate_eff`, and the clock generator, which is outside this block, follows that code.

The mode bit selects one of two ways to apply a new code. In immediate mode the code reaches `rate_eff` exactly four cycles after the write. In deferred mode the code is only held as pending. It is applied while the clock is stopped during standby. On a wake event the block releases the clock and keeps `running` low for a programmable number of cycles. It then resumes at the new rate.

Top module: `rate_switch_ctrl`

## Requirements
- R1: Rate codes are 2'b00 = oscillator x1, 2'b01 = x2 and 2'b10 = divide by 2. `rate_eff` never shows 2'b11.
- R2: After a synchronous reset, `rate_eff` and `rate_rd` are 2'b00, `running` is 1, and `clk_stop` and `in_standby` are 0.
- R3: A write with `wr_rate` = 2'b11 (the reserved code) is ignored. The pending value read back on `rate_rd` and the value on `rate_eff` both stay unchanged.
- R4: `rate_rd` shows the pending rate code from the cycle after the write edge onward.
- R5: With `wr_imm` = 0, a write does not change `rate_eff` while the block is running.
- R6: When `sleep_req` is sampled high while the block is running, `clk_stop` and `in_standby` go to 1 and `running` goes to 0 on the next cycle. One cycle after that, `rate_eff` equals the pending code.
- R7: A `wake` sampled high while the clock is stopped drops `clk_stop` on the next cycle. `running` then stays 0 until exactly (F+1)*256 cycles after the wake edge, where F is the wait field. At that point `running` goes to 1 and `in_standby` goes to 0.
- R8: A `wake` that arrives during the wait count neither restarts it nor shortens it.
- R9: With `wr_imm` = 1 and a legal code, `rate_eff` keeps its old value for three cycles after the write edge. It shows the new code from the fourth cycle onward.
- R10: `wake` while running has no effect, and `sleep_req` while in standby has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain control clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_rate | input | 2 | Rate code to write |
| wr_imm | input | 1 | Mode bit: 1 = immediate, 0 = deferred until standby |
| wr_wait | input | 4 | Wake-up wait field F, giving a wait of (F+1)*256 cycles |
| sleep_req | input | 1 | Request to enter standby |
| wake | input | 1 | Wake event that ends standby |
| rate_rd | output | 2 | Pending rate code (read value) |
| rate_eff | output | 2 | Effective rate code |
| clk_stop | output | 1 | Stop signal to the clock generator |
| in_standby | output | 1 | High from standby entry until operation resumes |
| running | output | 1 | High during normal operation |

## Verification
Every output is registered. A sleep request is therefore visible one cycle after its edge, and the pending code reaches `rate_eff` one cycle after that. An immediate write reaches `rate_eff` on the fourth cycle after its edge. The release of `running` comes exactly (F+1)*256 cycles after the wake edge. The bench drives inputs on falling edges and samples on falling edges. For each result it counts edges to land on the cycle just before the due cycle and on the due cycle itself, so a result that arrives one cycle early or one cycle late is reported.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int RATE_W = 2;

  typedef enum logic [1:0] {
    RATE_X1   = 2'b00,
    RATE_X2   = 2'b01,
    RATE_DIV2 = 2'b10,
    RATE_RSV  = 2'b11
  } rate_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_STOP = 2'b01,
    ST_WAIT = 2'b10
  } seq_e;

  typedef struct packed {
    logic  vld;
    rate_e code;
  } imm_req_t;
endpackage

// File: rtl/rsc_cfg_regs.sv
module rsc_cfg_regs
  import rsc_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  rate_e             wr_rate,
  input  logic              wr_imm,
  input  logic [WAIT_W-1:0] wr_wait,
  output rate_e             pend_rate,
  output logic [WAIT_W-1:0] wait_fld,
  output imm_req_t          imm_req
);
  logic legal;
  assign legal = (wr_rate != RATE_RSV);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_rate <= RATE_X1;
      wait_fld  <= '0;
    end else if (wr_en) begin
      wait_fld <= wr_wait;
      if (legal) pend_rate <= wr_rate;
    end
  end

  always_comb begin
    imm_req.vld  = wr_en && wr_imm && legal;
    imm_req.code = wr_rate;
  end
endmodule

// File: rtl/rsc_imm_pipe.sv
module rsc_imm_pipe
  import rsc_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  imm_req_t req_in,
  output imm_req_t req_out
);
  imm_req_t stg [LAT-1];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= req_in;
  end

  for (genvar i = 1; i < LAT - 1; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign req_out = stg[LAT-2];
endmodule

// File: rtl/rsc_seq.sv
module rsc_seq
  import rsc_pkg::*;
#(
  parameter int WAIT_W   = 4,
  parameter int UNIT_LOG = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_req,
  input  logic              wake,
  input  logic [WAIT_W-1:0] wait_fld,
  output seq_e              state,
  output logic              clk_stop,
  output logic              in_standby,
  output logic              running
);
  localparam int CNT_W = WAIT_W + UNIT_LOG;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RUN;
      clk_stop   <= 1'b0;
      in_standby <= 1'b0;
      running    <= 1'b1;
      cnt        <= '0;
    end else begin
      unique case (state)
        ST_RUN: if (sleep_req) begin
          state      <= ST_STOP;
          clk_stop   <= 1'b1;
          in_standby <= 1'b1;
          running    <= 1'b0;
        end
        ST_STOP: if (wake) begin
          state    <= ST_WAIT;
          clk_stop <= 1'b0;
          cnt      <= {wait_fld, {UNIT_LOG{1'b1}}};
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            state      <= ST_RUN;
            running    <= 1'b1;
            in_standby <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/rate_switch_ctrl.sv
module rate_switch_ctrl
  import rsc_pkg::*;
#(
  parameter int WAIT_W   = 4,
  parameter int UNIT_LOG = 8,
  parameter int IMM_LAT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_rate,
  input  logic              wr_imm,
  input  logic [WAIT_W-1:0] wr_wait,
  input  logic              sleep_req,
  input  logic              wake,
  output logic [1:0]        rate_rd,
  output logic [1:0]        rate_eff,
  output logic              clk_stop,
  output logic              in_standby,
  output logic              running
);
  rate_e             pend_rate;
  logic [WAIT_W-1:0] wait_fld;
  imm_req_t          req_new, req_due;
  seq_e              state;

  rsc_cfg_regs #(.WAIT_W(WAIT_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_rate(rate_e'(wr_rate)),
    .wr_imm(wr_imm), .wr_wait(wr_wait), .pend_rate(pend_rate),
    .wait_fld(wait_fld), .imm_req(req_new)
  );

  rsc_imm_pipe #(.LAT(IMM_LAT)) u_pipe (
    .clk(clk), .rst(rst), .req_in(req_new), .req_out(req_due)
  );

  rsc_seq #(.WAIT_W(WAIT_W), .UNIT_LOG(UNIT_LOG)) u_seq (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake(wake),
    .wait_fld(wait_fld), .state(state), .clk_stop(clk_stop),
    .in_standby(in_standby), .running(running)
  );

  always_ff @(posedge clk) begin
    if (rst)                 rate_eff <= RATE_X1;
    else if (state != ST_RUN) rate_eff <= pend_rate;
    else if (req_due.vld)     rate_eff <= req_due.code;
  end

  assign rate_rd = pend_rate;
endmodule

// File: rtl/rate_switch_ctrl_chk.sv
module rate_switch_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] wr_rate,
  input logic       wr_imm,
  input logic [1:0] rate_rd,
  input logic [1:0] rate_eff,
  input logic       clk_stop,
  input logic       in_standby,
  input logic       running
);
  assert_eff_legal_R1: assert property (@(posedge clk) disable iff (rst)
    rate_eff != 2'b11);

  assert_pend_legal_R3: assert property (@(posedge clk) disable iff (rst)
    rate_rd != 2'b11);

  assert_stop_flags_R6: assert property (@(posedge clk) disable iff (rst)
    clk_stop |-> (in_standby && !running));

  assert_stop_applies_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_stop) |-> rate_eff == $past(rate_rd));

  assert_resume_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> ($past(in_standby) && !$past(clk_stop) && !in_standby));

  assert_imm_latency_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && wr_imm && wr_rate != 2'b11, 4) && running && $past(running, 4))
      |-> rate_eff == $past(wr_rate, 4));
endmodule

bind rate_switch_ctrl rate_switch_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_rate(wr_rate), .wr_imm(wr_imm),
  .rate_rd(rate_rd), .rate_eff(rate_eff), .clk_stop(clk_stop),
  .in_standby(in_standby), .running(running)
);

// File: tb/test_rate_switch_ctrl.sv
module test_rate_switch_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_imm = 1'b0, sleep_req = 1'b0, wake = 1'b0;
  logic [1:0] wr_rate = 2'b00;
  logic [3:0] wr_wait = 4'd0;
  logic [1:0] rate_rd, rate_eff;
  logic       clk_stop, in_standby, running;
  int total = 0, bad = 0;
  logic [1:0] exp_pend = 2'b00, exp_eff = 2'b00;

  always #10 clk = ~clk;

  rate_switch_ctrl i_rate_switch_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_rate(wr_rate), .wr_imm(wr_imm),
    .wr_wait(wr_wait), .sleep_req(sleep_req), .wake(wake), .rate_rd(rate_rd),
    .rate_eff(rate_eff), .clk_stop(clk_stop), .in_standby(in_standby),
    .running(running)
  );

  function automatic logic [1:0] next_pend(logic [1:0] old, logic [1:0] code);
    return (code == 2'b11) ? old : code;
  endfunction

  function automatic int wait_cycles(logic [3:0] f);
    return (int'(f) + 1) * 256;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns at the falling edge after the write edge
  task automatic do_write(logic [1:0] code, logic imm, logic [3:0] wt);
    @(negedge clk);
    wr_en = 1'b1; wr_rate = code; wr_imm = imm; wr_wait = wt;
    @(negedge clk);
    wr_en = 1'b0;
    exp_pend = next_pend(exp_pend, code);
  endtask

  task automatic pulse(input bit is_wake);
    @(negedge clk);
    if (is_wake) wake = 1'b1; else sleep_req = 1'b1;
    @(negedge clk);
    wake = 1'b0; sleep_req = 1'b0;
  endtask

  task automatic standby_cycle(logic [3:0] f, bit poke);
    int n;
    n = wait_cycles(f);
    pulse(1'b0);
    check("R6 clk_stop", clk_stop, 1);
    check("R6 in_standby", in_standby, 1);
    check("R6 running", running, 0);
    pulse(1'b0);
    check("R10 sleep in standby", {clk_stop, in_standby, running}, 3'b110);
    exp_eff = exp_pend;
    check("R6 eff applied", rate_eff, exp_eff);
    pulse(1'b1);
    check("R7 clk released", clk_stop, 0);
    check("R7 held", running, 0);
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      wake = (poke && i == 100);
      if (i == n - 1) begin
        check("R8 still waiting", running, 0);
        check("R7 standby kept", in_standby, 1);
      end
    end
    @(negedge clk);
    check("R7 running resumed", running, 1);
    check("R7 standby cleared", in_standby, 0);
    check("R7 rate kept", rate_eff, exp_eff);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2 eff", rate_eff, 0);
    check("R2 rd", rate_rd, 0);
    check("R2 flags", {running, clk_stop, in_standby}, 3'b100);

    // immediate writes, exact latency
    for (int k = 0; k < 30; k++) begin
      logic [1:0] code;
      code = 2'($urandom_range(0, 3));
      do_write(code, 1'b1, 4'd0);
      check("R4 readback", rate_rd, exp_pend);
      repeat (2) @(negedge clk);
      check("R9 not yet", rate_eff, exp_eff);
      @(negedge clk);
      if (code != 2'b11) exp_eff = code;
      check("R9 applied", rate_eff, exp_eff);
      check("R1 legal", rate_eff != 2'b11, 1);
    end

    // reserved code directed
    do_write(2'b01, 1'b1, 4'd0);
    repeat (3) @(negedge clk);
    exp_eff = 2'b01;
    do_write(2'b11, 1'b1, 4'd0);
    check("R3 pend kept", rate_rd, 2'b01);
    repeat (5) @(negedge clk);
    check("R3 eff kept", rate_eff, 2'b01);

    // deferred writes have no effect while running
    for (int k = 0; k < 10; k++) begin
      do_write(2'($urandom_range(0, 3)), 1'b0, 4'd0);
      check("R4 readback deferred", rate_rd, exp_pend);
      repeat (6) @(negedge clk);
      check("R5 eff unchanged", rate_eff, exp_eff);
    end

    // wake while running
    pulse(1'b1);
    check("R10 wake running", {running, clk_stop, in_standby}, 3'b100);

    do_write(2'b10, 1'b0, 4'd0);
    standby_cycle(4'd0, 1'b0);
    do_write(2'b01, 1'b0, 4'd2);
    check("R5 before standby", rate_eff, 2'b10);
    standby_cycle(4'd2, 1'b1);
    check("R1 after standby", rate_eff, 2'b01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule